// File: doc/BRIEF.md
# Predicated Contiguous Vector Byte Loader

This block carries out a single predicated, contiguous byte load into a vector register. A one-cycle start pulse presents a 32-bit instruction word together with the already-fetched base value, a flag that says whether the stack pointer is misaligned, and the per-lane predicate mask. The register files sit outside the block. The block decodes the instruction combinationally, so the surrounding logic can select the base and predicate sources in the same cycle.

Once a load is accepted, the block visits every lane in ascending order. For each lane whose predicate bit is set, it issues one byte read. The lane address is the base plus a signed 4-bit immediate times the vector length, plus the lane number, computed with 64-bit wrap-around. Every read carries a streaming hint. Lanes that are not selected are never read and come back as zero. The assembled vector appears on the result port together with a one-cycle done pulse.

A malformed instruction word raises an undefined flag. A stack-pointer base that is misaligned raises an alignment fault before any read is issued.

Top module: `pred_byte_loader`

## Requirements
- R1: A start is legal only when instruction bits 31:20 equal 12'hA40 and bits 15:13 equal 3'b111. Any other word gives an `undef` pulse in the cycle after start, with no read issued and `busy` left low.
- R2: Lane e reads the address base + (sext(insn[19:16]) × ELEMS + e), taken modulo 2^64.
- R3: Lanes are fetched strictly in ascending order, with at most one read outstanding. A new request is never raised while an earlier read has not yet returned `mem_rvalid`.
- R4: A lane whose predicate bit is 0 issues no memory read.
- R5: Result bits [8e+7:8e] hold the byte returned for lane e when that lane is active, and zero otherwise.
- R6: `mem_stream` is high in every cycle in which `mem_req` is high.
- R7: When insn[9:5] = 31, `sp_misaligned` is high and at least one predicate bit is set, an `align_fault` pulse follows in the cycle after start. No read is issued and `busy` stays low.
- R8: When insn[9:5] = 31, `sp_misaligned` is high and no predicate bit is set, the block raises the fault if CHECK_IDLE_SP = 1. Otherwise it completes with a zero result.
- R9: `busy` rises in the cycle after an accepted start and is low from the cycle in which `done` is high. A start that arrives while `busy` is high is ignored.
- R10: `done` is a one-cycle pulse. `result` changes only in a cycle in which `done` is high.
- R11: `src_base_sel` equals insn[9:5] and `src_pred_sel` equals insn[12:10] combinationally. `dst_idx` equals insn[4:0] of the completed load when `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle load request |
| insn | input | 32 | Instruction word |
| base | input | 64 | Base address value (stack pointer when insn[9:5] = 31) |
| sp_misaligned | input | 1 | Stack pointer alignment status |
| pred | input | ELEMS | Per-lane predicate mask |
| src_base_sel | output | 5 | Decoded base register index |
| src_pred_sel | output | 3 | Decoded predicate register index |
| busy | output | 1 | Load in progress |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 64 | Read address |
| mem_stream | output | 1 | Non-temporal hint for the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | Completion pulse |
| undef | output | 1 | Undefined-encoding pulse |
| align_fault | output | 1 | Stack alignment fault pulse |
| dst_idx | output | 5 | Destination register index of the completed load |
| result | output | 8*ELEMS | Assembled vector |

## Verification
The bench builds the block with ELEMS = 16 and CHECK_IDLE_SP = 1. This makes the immediate scaling by 16 visible: -8 steps the base back by 128 bytes and 7 steps it forward by 112, so bases near zero and near the top of the 64-bit space reach both wrap directions. It also brings the optional empty-predicate stack-pointer fault into reach. A memory responder with programmable latency shows that requests are serialised, and a second start injected mid-load shows that the block ignores it.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
   localparam int unsigned ADDR_W = 64;
   localparam logic [11:0] OPC_HI  = 12'hA40;
   localparam logic [2:0]  OPC_MID = 3'b111;
   localparam logic [4:0]  SP_IDX  = 5'd31;

   typedef struct packed {
      logic       legal;
      logic [3:0] imm;
      logic [2:0] pg;
      logic [4:0] rn;
      logic [4:0] zt;
   } ld_fields_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_WAIT = 2'd2
   } ld_state_t;
endpackage

// File: rtl/pbl_decode.sv
module pbl_decode
   import pbl_pkg::*;
(
   input  logic [31:0] insn,
   output ld_fields_t  fields
);
   always_comb begin
      fields.legal = (insn[31:20] == OPC_HI) && (insn[15:13] == OPC_MID);
      fields.imm   = insn[19:16];
      fields.pg    = insn[12:10];
      fields.rn    = insn[9:5];
      fields.zt    = insn[4:0];
   end
endmodule

// File: rtl/pbl_agen.sv
module pbl_agen
   import pbl_pkg::*;
#(
   parameter int ELEMS = 16,
   parameter int EW    = 5
)(
   input  logic [ADDR_W-1:0] base,
   input  logic [3:0]        imm,
   input  logic [EW-1:0]     elem,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] imm_ext;
   logic [ADDR_W-1:0] lane_off;

   always_comb begin
      imm_ext  = {{(ADDR_W-4){imm[3]}}, imm};
      lane_off = imm_ext * ADDR_W'(ELEMS) + ADDR_W'(elem);
      addr     = base + lane_off;
   end
endmodule

// File: rtl/pred_byte_loader.sv
module pred_byte_loader
   import pbl_pkg::*;
#(
   parameter int ELEMS         = 16,
   parameter bit CHECK_IDLE_SP = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [31:0]          insn,
   input  logic [63:0]          base,
   input  logic                 sp_misaligned,
   input  logic [ELEMS-1:0]     pred,
   output logic [4:0]           src_base_sel,
   output logic [2:0]           src_pred_sel,
   output logic                 busy,
   output logic                 mem_req,
   output logic [63:0]          mem_addr,
   output logic                 mem_stream,
   input  logic                 mem_rvalid,
   input  logic [7:0]           mem_rdata,
   output logic                 done,
   output logic                 undef,
   output logic                 align_fault,
   output logic [4:0]           dst_idx,
   output logic [8*ELEMS-1:0]   result
);
   localparam int IW = $clog2(ELEMS);
   localparam int EW = IW + 1;

   if (ELEMS < 2 || ELEMS > 2048 || (ELEMS & (ELEMS - 1)) != 0) begin : g_bad_elems
      $error("pred_byte_loader: ELEMS must be a power of two in 2..2048");
   end

   ld_fields_t              dec_now;
   ld_state_t               st_q;
   logic [3:0]              imm_q;
   logic [4:0]              zt_q;
   logic [63:0]             base_q;
   logic [ELEMS-1:0]        pred_q;
   logic [EW-1:0]           e_q;
   logic [ELEMS-1:0][7:0]   lanes_q;
   logic [ELEMS-1:0][7:0]   res_q;
   logic                    done_q, undef_q, fault_q;
   logic                    sp_gate, sp_fault_now, at_end, cur_active;

   pbl_decode u_dec (.insn(insn), .fields(dec_now));

   pbl_agen #(.ELEMS(ELEMS), .EW(EW)) u_agen (
      .base (base_q),
      .imm  (imm_q),
      .elem (e_q),
      .addr (mem_addr)
   );

   if (CHECK_IDLE_SP) begin : g_chk_idle
      assign sp_gate = 1'b1;
   end else begin : g_skip_idle
      assign sp_gate = |pred;
   end

   assign sp_fault_now = (dec_now.rn == SP_IDX) && sp_misaligned && sp_gate;
   assign at_end       = (e_q == EW'(ELEMS));
   assign cur_active   = !at_end && pred_q[e_q[IW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         imm_q   <= '0;
         zt_q    <= '0;
         base_q  <= '0;
         pred_q  <= '0;
         e_q     <= '0;
         lanes_q <= '0;
         res_q   <= '0;
         done_q  <= 1'b0;
         undef_q <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         undef_q <= 1'b0;
         fault_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  if (!dec_now.legal) begin
                     undef_q <= 1'b1;
                  end else if (sp_fault_now) begin
                     fault_q <= 1'b1;
                  end else begin
                     imm_q   <= dec_now.imm;
                     zt_q    <= dec_now.zt;
                     base_q  <= base;
                     pred_q  <= pred;
                     e_q     <= '0;
                     lanes_q <= '0;
                     st_q    <= ST_SCAN;
                  end
               end
            end
            ST_SCAN: begin
               if (at_end) begin
                  res_q  <= lanes_q;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else if (cur_active) begin
                  st_q <= ST_WAIT;
               end else begin
                  e_q <= e_q + 1'b1;
               end
            end
            ST_WAIT: begin
               if (mem_rvalid) begin
                  lanes_q[e_q[IW-1:0]] <= mem_rdata;
                  e_q                  <= e_q + 1'b1;
                  st_q                 <= ST_SCAN;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign src_base_sel = dec_now.rn;
   assign src_pred_sel = dec_now.pg;
   assign busy         = (st_q != ST_IDLE);
   assign mem_req      = (st_q == ST_SCAN) && cur_active;
   assign mem_stream   = mem_req;
   assign done         = done_q;
   assign undef        = undef_q;
   assign align_fault  = fault_q;
   assign dst_idx      = zt_q;
   assign result       = res_q;

   assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_undef_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> (!busy && !mem_req && $past(start)));
   assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> (!busy && !mem_req && $past(start)));
endmodule

// File: tb/tb_pred_byte_loader.sv
`timescale 1ns/1ps
module tb_pred_byte_loader;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] insn_i = '0;
   logic [63:0] base_i = '0;
   logic mis_i = 1'b0;
   logic [N-1:0] pred_i = '0;
   logic [4:0] src_base_sel;
   logic [2:0] src_pred_sel;
   logic busy, mem_req, mem_stream, done, undef, align_fault;
   logic [63:0] mem_addr;
   logic mem_rvalid = 1'b0;
   logic [7:0] mem_rdata = '0;
   logic [4:0] dst_idx;
   logic [8*N-1:0] result;

   int errors = 0, checks = 0, reads = 0, lat = 0, cycles = 0;
   logic [63:0] exp_q[$];
   logic [8*N-1:0] last_res = '0;
   logic pend = 1'b0;
   logic [63:0] paddr = '0;
   int cnt = 0;

   always #5 clk = ~clk;

   pred_byte_loader #(.ELEMS(N), .CHECK_IDLE_SP(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .insn(insn_i), .base(base_i),
      .sp_misaligned(mis_i), .pred(pred_i), .src_base_sel(src_base_sel),
      .src_pred_sel(src_pred_sel), .busy(busy), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_stream(mem_stream), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .done(done), .undef(undef),
      .align_fault(align_fault), .dst_idx(dst_idx), .result(result));

   function automatic logic [7:0] mb(input logic [63:0] a);
      return a[7:0] ^ a[15:8] ^ a[63:56] ^ 8'h5A;
   endfunction

   function automatic logic [31:0] mk(input logic [3:0] im, input logic [2:0] pg,
                                      input logic [4:0] rn, input logic [4:0] zt);
      return {12'hA40, im, 3'b111, pg, rn, zt};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // memory responder with programmable latency
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         pend  <= 1'b1;
         paddr <= mem_addr;
         cnt   <= lat;
      end else if (pend) begin
         if (cnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mb(paddr);
            pend       <= 1'b0;
         end else begin
            cnt <= cnt - 1;
         end
      end
   end

   // reference comparison on every clock
   always @(negedge clk) begin
      logic [63:0] h;
      cycles++;
      if (rst_n) begin
         if (mem_req) begin
            reads++;
            chk(mem_stream, "R6", "stream hint", 128'(mem_stream), 128'(1));
            chk(!pend, "R3", "request while read outstanding", 128'(pend), 128'(0));
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected read", 128'(mem_addr), 128'(0));
            end else begin
               h = exp_q.pop_front();
               chk(mem_addr == h, "R2", "lane address/order", 128'(mem_addr), 128'(h));
            end
         end
         if (!done && result != last_res)
            chk(1'b0, "R10", "result moved without done", 128'(result), 128'(last_res));
         last_res = result;
      end
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // kind: 0 completes, 1 undefined, 2 alignment fault
   task automatic run_case(input string nm, input logic [31:0] ins, input logic [63:0] b,
                           input logic mis, input logic [N-1:0] p, input int lt,
                           input bit poke, input int kind);
      logic [8*N-1:0] er;
      logic [63:0] a;
      int nexp, cyc;
      er = '0; nexp = 0; exp_q.delete();
      if (kind == 0)
         for (int e = 0; e < N; e++)
            if (p[e]) begin
               a = b + {{60{ins[19]}}, ins[19:16]} * 64'(N) + 64'(e);
               exp_q.push_back(a);
               er[8*e +: 8] = mb(a);
               nexp++;
            end
      @(negedge clk);
      lat = lt; reads = 0;
      insn_i = ins; base_i = b; mis_i = mis; pred_i = p; start = 1'b1;
      #1;
      chk(src_base_sel == ins[9:5] && src_pred_sel == ins[12:10], "R11",
          {nm, " source selectors"}, 128'({src_base_sel, src_pred_sel}),
          128'({ins[9:5], ins[12:10]}));
      @(negedge clk);
      start = 1'b0;
      if (kind == 0) begin
         chk(busy, "R9", {nm, " busy after start"}, 128'(busy), 128'(1));
         cyc = 0;
         while (!done && cyc < 3000) begin
            if (poke && cyc == 2) begin
               insn_i = mk(4'd1, 3'd0, 5'd2, 5'd9); pred_i = '1; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
         end
         start = 1'b0;
         chk(done, "R10", {nm, " done seen"}, 128'(done), 128'(1));
         chk(result == er, "R5", {nm, " result"}, 128'(result), 128'(er));
         chk(reads == nexp, "R4", {nm, " read count"}, 128'(reads), 128'(nexp));
         chk(exp_q.size() == 0, "R2", {nm, " all lanes read"}, 128'(exp_q.size()), 128'(0));
         chk(!busy, "R9", {nm, " busy low at done"}, 128'(busy), 128'(0));
         chk(dst_idx == ins[4:0], "R11", {nm, " destination"}, 128'(dst_idx), 128'(ins[4:0]));
         @(negedge clk);
         chk(!done, "R10", {nm, " done one cycle"}, 128'(done), 128'(0));
      end else begin
         if (kind == 1)
            chk(undef && !busy, "R1", {nm, " undef pulse"}, 128'({undef, busy}), 128'(2'b10));
         else
            chk(align_fault && !busy, "R7", {nm, " fault pulse"}, 128'({align_fault, busy}), 128'(2'b10));
         repeat (4) @(negedge clk);
         chk(reads == 0 && !busy && !done, kind == 1 ? "R1" : "R7", {nm, " no reads"},
             128'(reads), 128'(0));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_req && result == '0, "R9", "reset state",
          128'({busy, done, mem_req}), 128'(0));
      run_case("all active imm0", mk(4'd0, 3'd1, 5'd3, 5'd7), 64'h1000, 1'b0, '1, 0, 1'b0, 0);
      run_case("all inactive", mk(4'd2, 3'd2, 5'd3, 5'd1), 64'h2000, 1'b0, '0, 0, 1'b0, 0);
      run_case("imm -8 wrap low", mk(4'h8, 3'd3, 5'd4, 5'd12), 64'h40, 1'b0, 16'hA5C3, 2, 1'b0, 0);
      run_case("imm 7 wrap high", mk(4'h7, 3'd4, 5'd6, 5'd30), 64'hFFFF_FFFF_FFFF_FF90, 1'b0, 16'h8001, 1, 1'b0, 0);
      run_case("sp misaligned active", mk(4'd0, 3'd0, 5'd31, 5'd2), 64'h1003, 1'b1, 16'h0010, 0, 1'b0, 2);
      run_case("R8 sp misaligned empty", mk(4'd0, 3'd0, 5'd31, 5'd2), 64'h1003, 1'b1, '0, 0, 1'b0, 2);
      run_case("sp aligned", mk(4'hF, 3'd5, 5'd31, 5'd4), 64'h8000, 1'b0, 16'h00F0, 0, 1'b0, 0);
      run_case("misaligned flag non-sp", mk(4'd3, 3'd6, 5'd5, 5'd5), 64'h300, 1'b1, 16'h0F0F, 1, 1'b0, 0);
      run_case("bad low opcode", {12'hA40, 4'd0, 3'b110, 13'h0}, 64'h0, 1'b0, '1, 0, 1'b0, 1);
      run_case("bad high opcode", {12'hA41, 4'd0, 3'b111, 13'h0}, 64'h0, 1'b0, '1, 0, 1'b0, 1);
      run_case("start while busy", mk(4'd1, 3'd7, 5'd8, 5'd17), 64'h5000, 1'b0, 16'h3C3C, 3, 1'b1, 0);
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule